// File: doc/BRIEF.md
# Write-Through Parity Data Cache

This block is a direct-mapped data cache for a 32-bit processor. Each line holds one 32-bit word, and lines are indexed and tagged by physical address. A static mode input selects 4 KB or 8 KB of capacity. Every load looks up the line and checks the valid bit, the tag, and the parity over both the stored tag and the stored data word. If any of these fails, the load is reported as a miss and the cache starts a refill. The refill is either the single missed word or the aligned group of four words that contains it, chosen per request.

The write policy is write-through. Every store is sent to a write-buffer port in the cycle it resolves. A store that hits replaces the cached word and regenerates its data parity. A store that misses leaves the cache unchanged.

A separate invalidate port lets another bus master, such as a DMA engine, keep the cache coherent. It presents the physical address it has written, and the matching line is dropped only if its tag matches. The CPU side handles one request at a time through a ready/valid pair. Every request receives exactly one response.

Top module: `pdcache_top`

## Requirements
- R1: In 4 KB mode (`bigCache`=0) the line index is address bits [11:2]; in 8 KB mode it is bits [12:2]. The tag is bits [31:12]. Two addresses 4 KB apart therefore evict each other in 4 KB mode but coexist in 8 KB mode.
- R2: A load that hits gives `rspValid`=1, `rspHit`=1 and the cached word on `rspData` in the cycle after it was accepted.
- R3: A load misses when any of these holds: the line is invalid, the tag differs, or the stored data or tag parity is wrong. A miss gives no response in the cycle after acceptance. The cache then refills, and it answers with `rspHit`=0 and the requested word in the cycle the last refill word is presented.
- R4: `quadRefill` is sampled at acceptance. When it is 0, `fillAddr` is the requested word address and one word is taken. When it is 1, `fillAddr` is the address with bits [3:0] cleared and four words are taken in ascending address order. Every refilled word becomes a valid line.
- R5: `fillPar` is stored as the data parity bit. Its correct value is the XOR of all bits of `fillData`; a wrong value makes later loads of that word miss. Tag parity is generated inside the block.
- R6: Every store, hit or miss, raises `wbValid` together with its response, one cycle after acceptance. `wbAddr` carries the word-aligned address and `wbData` the store data.
- R7: A store hits when the line is valid and its tag matches with correct tag parity; data parity is ignored. A hit replaces the word and regenerates its parity. A store miss reports `rspHit`=0, requests no refill and allocates nothing.
- R8: An invalidate clears the line at its index only when that line is valid and its tag equals the invalidate address tag. Otherwise it has no effect.
- R9: An invalidate wins over a same-cycle CPU access to the same address. The load or store reports a miss, no store update happens, and the line ends invalid. A refill word written in the same cycle to the invalidated address is also left invalid.
- R10: `reqReady` is high only when no request is in progress, and reset clears every valid bit.
- R11: `fillReq` stays high, and `fillAddr` stays stable, from the cycle after a load miss until the last refill word is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bigCache | input | 1 | 1 selects 8 KB, 0 selects 4 KB; change only under reset |
| quadRefill | input | 1 | 1 requests a four-word refill on a load miss |
| reqValid | input | 1 | CPU request present |
| reqReady | output | 1 | Cache can accept a request |
| reqWrite | input | 1 | 1 for store, 0 for load |
| reqAddr | input | 32 | Physical byte address of the request |
| reqWdata | input | 32 | Store data |
| rspValid | output | 1 | Response for the current request |
| rspHit | output | 1 | Request hit in the cache |
| rspData | output | 32 | Load data |
| wbValid | output | 1 | Store issued to the write buffer |
| wbAddr | output | 32 | Word-aligned store address |
| wbData | output | 32 | Store data |
| fillReq | output | 1 | Refill in progress |
| fillAddr | output | 32 | First word address of the refill |
| fillValid | input | 1 | Refill word presented this cycle |
| fillData | input | 32 | Refill word |
| fillPar | input | 1 | Parity bit supplied with the refill word |
| invValid | input | 1 | Coherency invalidate request |
| invAddr | input | 32 | Physical address to invalidate |

## Verification
The bench aims at the following corner cases:
- Aliasing at 4 KB spacing in both capacity modes. If the index width ignored the mode, the 8 KB mode would thrash instead of holding both lines.
- A refill delivered with bad parity. The next load must miss and refill again. A cache that trusted the stored word would return it as a hit.
- A store that hits such a corrupted line. It must repair the word so the following load hits. A design that demanded good data parity for stores would never recover the line.
- An invalidate carrying a foreign tag, and one arriving in the very cycle a load or store looks up the line. A design without tag comparison or without priority would drop a live line or report a stale hit.
- Store misses. These must reach the write-buffer port without allocating a line.

// File: rtl/pdcache_pkg.sv
`timescale 1ns/1ps
package pdcache_pkg;

  // words per refill group is 2**GRP_W
  localparam int GRP_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_FILL
  } pdState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             latchReq;
    logic             storeUpd;
    logic             fillWr;
    logic             rspFromFill;
    logic [GRP_W-1:0] fillOfs;
  } pdStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic loadHit;
    logic storeHit;
    logic isWrite;
    logic isQuad;
  } pdStatus_t;

endpackage

// File: rtl/pdcache_ctl.sv
`timescale 1ns/1ps
module pdcache_ctl
  import pdcache_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      fillValid,
  input  pdStatus_t st,
  output pdStrobe_t stb,
  output logic      reqReady,
  output logic      rspValid,
  output logic      rspHit,
  output logic      wbValid,
  output logic      fillReq
);

  pdState_e         state, stateNx;
  logic [GRP_W-1:0] cnt, cntNx;
  logic             lastWord;

  assign lastWord = st.isQuad ? (cnt == '1) : (cnt == '0);

  always_comb begin
    stateNx  = state;
    cntNx    = cnt;
    stb      = '0;
    reqReady = 1'b0;
    rspValid = 1'b0;
    rspHit   = 1'b0;
    wbValid  = 1'b0;
    fillReq  = 1'b0;
    case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.latchReq = 1'b1;
          stateNx      = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (st.isWrite) begin
          rspValid     = 1'b1;
          rspHit       = st.storeHit;
          wbValid      = 1'b1;
          stb.storeUpd = st.storeHit;
          stateNx      = ST_IDLE;
        end else if (st.loadHit) begin
          rspValid = 1'b1;
          rspHit   = 1'b1;
          stateNx  = ST_IDLE;
        end else begin
          cntNx   = '0;
          stateNx = ST_FILL;
        end
      end
      ST_FILL: begin
        fillReq         = 1'b1;
        stb.rspFromFill = 1'b1;
        stb.fillOfs     = cnt;
        if (fillValid) begin
          stb.fillWr = 1'b1;
          if (lastWord) begin
            rspValid = 1'b1;
            stateNx  = ST_IDLE;
          end else begin
            cntNx = cnt + 1'b1;
          end
        end
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNx;
      cnt   <= cntNx;
    end
  end

endmodule

// File: rtl/pdcache_dp.sv
`timescale 1ns/1ps
module pdcache_dp
  import pdcache_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int SMALL_IDX_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bigCache,
  input  logic              quadRefill,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] fillData,
  input  logic              fillPar,
  input  logic              invValid,
  input  logic [ADDR_W-1:0] invAddr,
  input  pdStrobe_t         stb,
  output pdStatus_t         st,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [DATA_W-1:0] wbData,
  output logic [ADDR_W-1:0] fillAddr
);

  localparam int WORD_LSB = 2;
  localparam int IDX_W    = SMALL_IDX_W + 1;
  localparam int LINES    = 1 << IDX_W;
  localparam int TAG_W    = ADDR_W - WORD_LSB - SMALL_IDX_W;
  localparam logic [ADDR_W-1:0] WORD_MASK = ~(ADDR_W'((1 << WORD_LSB) - 1));
  localparam logic [ADDR_W-1:0] GRP_MASK  = ~(ADDR_W'((1 << (WORD_LSB + GRP_W)) - 1));

  function automatic logic [IDX_W-1:0] idxOf(input logic [ADDR_W-1:0] a, input logic big);
    logic [IDX_W-1:0] r;
    r = a[WORD_LSB +: IDX_W];
    if (!big) r[IDX_W-1] = 1'b0;
    return r;
  endfunction

  function automatic logic [TAG_W-1:0] tagOf(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  // line storage
  logic [DATA_W-1:0] dataMem [LINES];
  logic [TAG_W-1:0]  tagMem  [LINES];
  logic [LINES-1:0]  dparMem, tparMem, validVec;

  // latched request
  logic [ADDR_W-1:0] curAddr;
  logic [DATA_W-1:0] curData, capData;
  logic              curWrite, curQuad;

  logic [IDX_W-1:0]  curIdx, fIdx, invIdx;
  logic [TAG_W-1:0]  curTag, fTag, invTag;
  logic [ADDR_W-1:0] fillWordAddr;
  logic              lineTagOk, dataParOk, invKillsCur, invMatchStored, fillKilled;

  assign curIdx = idxOf(curAddr, bigCache);
  assign curTag = tagOf(curAddr);
  assign invIdx = idxOf(invAddr, bigCache);
  assign invTag = tagOf(invAddr);

  assign fillAddr     = curQuad ? (curAddr & GRP_MASK) : curAddr;
  assign fillWordAddr = fillAddr + (ADDR_W'(stb.fillOfs) << WORD_LSB);
  assign fIdx         = idxOf(fillWordAddr, bigCache);
  assign fTag         = tagOf(fillWordAddr);

  // lookup of the latched request
  assign lineTagOk   = validVec[curIdx] && (tagMem[curIdx] == curTag)
                       && (tparMem[curIdx] == ^tagMem[curIdx]);
  assign dataParOk   = (dparMem[curIdx] == ^dataMem[curIdx]);
  assign invKillsCur = invValid && (invIdx == curIdx) && (invTag == curTag);

  assign st.storeHit = lineTagOk && !invKillsCur;
  assign st.loadHit  = lineTagOk && dataParOk && !invKillsCur;
  assign st.isWrite  = curWrite;
  assign st.isQuad   = curQuad;

  // coherency lookup
  assign invMatchStored = invValid && validVec[invIdx] && (tagMem[invIdx] == invTag);
  assign fillKilled     = invValid && (invIdx == fIdx) && (invTag == fTag);

  assign rspData = stb.rspFromFill
                   ? ((fillWordAddr == curAddr) ? fillData : capData)
                   : dataMem[curIdx];
  assign wbAddr  = curAddr;
  assign wbData  = curData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr  <= '0;
      curData  <= '0;
      curWrite <= 1'b0;
      curQuad  <= 1'b0;
      capData  <= '0;
    end else begin
      if (stb.latchReq) begin
        curAddr  <= reqAddr & WORD_MASK;
        curData  <= reqWdata;
        curWrite <= reqWrite;
        curQuad  <= quadRefill;
      end
      if (stb.fillWr && (fillWordAddr == curAddr)) capData <= fillData;
    end
  end

  // valid bits: a refill word sets its line unless the same address is
  // invalidated in that cycle; an invalidate of a stored tag clears it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validVec <= '0;
    end else begin
      if (invMatchStored) validVec[invIdx] <= 1'b0;
      if (stb.fillWr)     validVec[fIdx]   <= !fillKilled;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.fillWr) begin
      dataMem[fIdx] <= fillData;
      dparMem[fIdx] <= fillPar;
      tagMem[fIdx]  <= fTag;
      tparMem[fIdx] <= ^fTag;
    end else if (stb.storeUpd) begin
      dataMem[curIdx] <= curData;
      dparMem[curIdx] <= ^curData;
    end
  end

endmodule

// File: rtl/pdcache_top.sv
`timescale 1ns/1ps
module pdcache_top
  import pdcache_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int SMALL_IDX_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bigCache,
  input  logic              quadRefill,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic              rspHit,
  output logic [DATA_W-1:0] rspData,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [DATA_W-1:0] wbData,
  output logic              fillReq,
  output logic [ADDR_W-1:0] fillAddr,
  input  logic              fillValid,
  input  logic [DATA_W-1:0] fillData,
  input  logic              fillPar,
  input  logic              invValid,
  input  logic [ADDR_W-1:0] invAddr
);

  pdStrobe_t stb;
  pdStatus_t st;

  pdcache_ctl uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .fillValid(fillValid),
    .st       (st),
    .stb      (stb),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .rspHit   (rspHit),
    .wbValid  (wbValid),
    .fillReq  (fillReq)
  );

  pdcache_dp #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .SMALL_IDX_W(SMALL_IDX_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .bigCache  (bigCache),
    .quadRefill(quadRefill),
    .reqWrite  (reqWrite),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .fillData  (fillData),
    .fillPar   (fillPar),
    .invValid  (invValid),
    .invAddr   (invAddr),
    .stb       (stb),
    .st        (st),
    .rspData   (rspData),
    .wbAddr    (wbAddr),
    .wbData    (wbData),
    .fillAddr  (fillAddr)
  );

endmodule

// File: rtl/pdcache_chk.sv
`timescale 1ns/1ps
module pdcache_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic              rspHit,
  input logic              wbValid,
  input logic              fillReq,
  input logic              fillValid,
  input logic [ADDR_W-1:0] fillAddr
);

  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  a_r3_no_rsp_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !rspValid);

  a_r2_hit_has_rsp: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> rspValid);

  a_r6_wb_with_rsp: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (rspValid && !fillReq));

  a_r11_fill_held: assert property (@(posedge clk) disable iff (!rstN)
    (fillReq && !fillValid) |=> fillReq);

  a_r11_fill_blocks: assert property (@(posedge clk) disable iff (!rstN)
    fillReq |-> !reqReady);

  a_r11_fill_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (fillReq && $past(fillReq)) |-> $stable(fillAddr));

  a_r4_fill_word_aligned: assert property (@(posedge clk) disable iff (!rstN)
    fillReq |-> (fillAddr[1:0] == 2'b00));

endmodule

bind pdcache_top pdcache_chk #(.ADDR_W(ADDR_W)) uChk (.*);

// File: tb/sim_pdcache_top.sv
`timescale 1ns/1ps
module sim_pdcache_top;

  logic        clk = 1'b0;
  logic        rstN, bigCache, quadRefill, reqValid, reqReady, reqWrite;
  logic [31:0] reqAddr, reqWdata, rspData, wbAddr, wbData, fillAddr, fillData, invAddr;
  logic        rspValid, rspHit, wbValid, fillReq, fillValid, fillPar, invValid;

  always #2 clk = ~clk;

  pdcache_top u0 (.*);

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // reference state
  int unsigned memArr [int unsigned];
  bit          mV   [2048];
  logic [19:0] mT   [2048];
  bit          mBad [2048];

  // results of the last access
  bit          gHit, gWb, gFill;
  logic [31:0] gData, gWbA, gWbD, gFA;
  int          gWords;

  function automatic logic [31:0] memRd(input logic [31:0] a);
    logic [31:0] w;
    w = a & ~32'h3;
    if (memArr.exists(w)) return memArr[w];
    return (w * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic int idxOf(input logic [31:0] a);
    return bigCache ? int'(a[12:2]) : int'(a[11:2]);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic doReset(input bit big);
    @(negedge clk);
    rstN = 1'b0; bigCache = big;
    reqValid = 0; reqWrite = 0; reqAddr = 0; reqWdata = 0; quadRefill = 0;
    fillValid = 0; fillData = 0; fillPar = 0; invValid = 0; invAddr = 0;
    for (int k = 0; k < 2048; k++) begin mV[k] = 0; mBad[k] = 0; mT[k] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R10", reqReady, 1, "ready after reset");
    chk(!rspValid && !fillReq && !wbValid, "R10", {rspValid, fillReq, wbValid}, 0,
        "outputs quiet after reset");
  endtask

  task automatic run(input bit wr, input logic [31:0] a, input logic [31:0] wd,
                     input bit quad, input int badOfs, input bit invLook);
    int cyc;
    logic [31:0] w, wv;
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = wd; quadRefill = quad;
    @(negedge clk);
    reqValid = 0;
    if (invLook) begin invValid = 1; invAddr = a; end
    gFill = 0; gWb = 0; gWords = 0; gHit = 0; gData = '0; cyc = 0;
    forever begin
      if (fillReq) begin
        if (!gFill) begin gFill = 1; gFA = fillAddr; end
        w  = gFA + 32'(gWords * 4);
        wv = memRd(w);
        fillValid = 1; fillData = wv;
        fillPar   = (^wv) ^ (gWords == badOfs);
        gWords++;
      end else begin
        fillValid = 0;
      end
      #1;
      if (wbValid) begin gWb = 1; gWbA = wbAddr; gWbD = wbData; end
      if (rspValid) begin gHit = rspHit; gData = rspData; break; end
      @(negedge clk);
      invValid = 0;
      cyc++;
      if (cyc > 20) begin
        chk(0, "R3", 0, 1, "no response");
        break;
      end
    end
    @(negedge clk);
    fillValid = 0; invValid = 0;
  endtask

  task automatic doLoad(input logic [31:0] a, input bit quad, input int badOfs,
                        input bit invLook);
    int i;
    logic [19:0] t;
    bit expHit;
    logic [31:0] expFA, w;
    int expN;
    i = idxOf(a); t = a[31:12];
    expHit = !invLook && mV[i] && (mT[i] == t) && !mBad[i];
    run(0, a, 32'h0, quad, badOfs, invLook);
    chk(gHit == expHit, expHit ? "R2" : "R3", gHit, expHit, "load hit");
    chk(gData == memRd(a), "R3", gData, memRd(a), "load data");
    if (invLook && mV[i] && (mT[i] == t)) mV[i] = 0;
    if (!expHit) begin
      expFA = quad ? (a & ~32'hF) : (a & ~32'h3);
      expN  = quad ? 4 : 1;
      chk(gFill && (gFA == expFA), "R4", gFA, expFA, "refill address");
      chk(gWords == expN, "R4", gWords, expN, "refill words");
      for (int k = 0; k < expN; k++) begin
        w = expFA + 32'(k * 4);
        mV[idxOf(w)]   = 1;
        mT[idxOf(w)]   = w[31:12];
        mBad[idxOf(w)] = (k == badOfs);
      end
    end else begin
      chk(!gFill, "R2", gFill, 0, "no refill on hit");
    end
  endtask

  task automatic doStore(input logic [31:0] a, input logic [31:0] wd, input bit invLook);
    int i;
    logic [19:0] t;
    bit expHit;
    i = idxOf(a); t = a[31:12];
    expHit = !invLook && mV[i] && (mT[i] == t);
    run(1, a, wd, 0, -1, invLook);
    chk(gHit == expHit, invLook ? "R9" : "R7", gHit, expHit, "store hit");
    chk(gWb && (gWbA == (a & ~32'h3)), "R6", gWbA, a & ~32'h3, "write-buffer address");
    chk(gWbD == wd, "R6", gWbD, wd, "write-buffer data");
    chk(!gFill, "R7", gFill, 0, "store causes no refill");
    memArr[a & ~32'h3] = wd;
    if (invLook && mV[i] && (mT[i] == t)) mV[i] = 0;
    if (expHit) mBad[i] = 0;
  endtask

  task automatic doInv(input logic [31:0] a);
    int i;
    i = idxOf(a);
    @(negedge clk);
    invValid = 1; invAddr = a;
    @(negedge clk);
    invValid = 0;
    if (mV[i] && (mT[i] == a[31:12])) mV[i] = 0;
  endtask

  task automatic randomOps(input int n);
    int r;
    logic [31:0] a;
    for (int k = 0; k < n; k++) begin
      r = int'($urandom % 10);
      a = 32'h0004_0000 + (($urandom % 4096) * 4);
      if (r < 6)      doLoad(a, 1'($urandom % 2), ($urandom % 8 == 0) ? int'($urandom % 4) : -1, 0);
      else if (r < 9) doStore(a, $urandom, 0);
      else begin
        memArr[a] = $urandom;   // another master writes memory, then invalidates
        doInv(a);
      end
    end
  endtask

  localparam logic [31:0] X = 32'h0004_0040;

  initial begin
    void'($urandom(32'd20240611));
    doReset(0);

    // R3/R4: first access misses with single-word refill, then R2 hit
    doLoad(X, 0, -1, 0);
    chk(gHit == 0, "R3", gHit, 0, "cold miss");
    doLoad(X, 0, -1, 0);
    chk(gHit == 1, "R2", gHit, 1, "hit after refill");
    // R1: 4 KB alias evicts in small mode
    doLoad(X + 32'h1000, 0, -1, 0);
    doLoad(X, 0, -1, 0);
    chk(gHit == 0, "R1", gHit, 0, "alias evicted in 4 KB mode");
    // R4: quad refill of aligned group
    doLoad(32'h0004_0124, 1, -1, 0);
    chk(gFA == 32'h0004_0120, "R4", gFA, 32'h0004_0120, "group base");
    doLoad(32'h0004_012C, 0, -1, 0);
    chk(gHit == 1, "R4", gHit, 1, "last word of group cached");
    // R5: bad refill parity becomes a miss
    doLoad(32'h0004_0200, 0, 0, 0);
    doLoad(32'h0004_0200, 0, -1, 0);
    chk(gHit == 0, "R5", gHit, 0, "parity error is a miss");
    doLoad(32'h0004_0200, 0, -1, 0);
    chk(gHit == 1, "R5", gHit, 1, "good parity hits");
    // R7: store hit repairs a bad-parity word
    doLoad(32'h0004_0300, 0, 0, 0);
    doStore(32'h0004_0300, 32'hCAFE_0001, 0);
    chk(gHit == 1, "R7", gHit, 1, "store hit on bad-parity line");
    doLoad(32'h0004_0300, 0, -1, 0);
    chk(gHit == 1 && gData == 32'hCAFE_0001, "R7", gData, 32'hCAFE_0001, "repaired word");
    // R7: store miss does not allocate
    doStore(32'h0004_0400, 32'h1234_5678, 0);
    doLoad(32'h0004_0400, 0, -1, 0);
    chk(gHit == 0, "R7", gHit, 0, "no write-allocate");
    // R8: foreign-tag invalidate is ignored, matching one clears
    doLoad(X, 0, -1, 0);
    doInv(X + 32'h2000);
    doLoad(X, 0, -1, 0);
    chk(gHit == 1, "R8", gHit, 1, "foreign tag invalidate ignored");
    memArr[X] = 32'hD0A0_BEEF;
    doInv(X);
    doLoad(X, 0, -1, 0);
    chk(gHit == 0 && gData == 32'hD0A0_BEEF, "R8", gData, 32'hD0A0_BEEF, "fresh data after invalidate");
    // R9: invalidate in the lookup cycle wins
    doLoad(X, 0, -1, 1);
    chk(gHit == 0, "R9", gHit, 0, "load killed by invalidate");
    doStore(X, 32'h5555_AAAA, 1);
    chk(gHit == 0, "R9", gHit, 0, "store killed by invalidate");
    doLoad(X, 0, -1, 0);
    chk(gHit == 0, "R9", gHit, 0, "line invalid after same-cycle invalidate");

    randomOps(300);

    // R1: 8 KB mode keeps both aliases
    doReset(1);
    doLoad(X, 0, -1, 0);
    doLoad(X + 32'h1000, 0, -1, 0);
    doLoad(X, 0, -1, 0);
    chk(gHit == 1, "R1", gHit, 1, "alias coexists in 8 KB mode");
    doLoad(X + 32'h1000, 0, -1, 0);
    chk(gHit == 1, "R1", gHit, 1, "second alias still cached");
    randomOps(300);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R10 watchdog act=%h exp=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule